// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block gathers service requests from six maskable event sources: two external lines, three timers and one serial channel. It turns them into a single request and vector number for a processor core. Each source keeps a pending flag, and every source except the serial one also has an event input. The serial channel keeps a receive flag and a transmit flag, and its request is the OR of the two. A master enable bit and one enable bit per source decide which flags may request service. One software priority bit per source places that source in an upper or a lower level. Inside one level, a fixed order picks the winner.

The core sees a registered request and the vector number of the winning source. It answers with an acknowledge pulse. On that pulse the block records the vector, clears that source's flag and marks the source's level as in service. A return strobe from the core ends the innermost active service. A lower-level service may be interrupted only by an upper-level request. While an upper-level service runs, nothing is taken. A small write port loads the enable register and the priority register, and it also lets software clear the serial flags.

Top module: `prio_intc`

## Requirements
- R1: After reset every pending flag, the enable register, the priority register and both in-service bits are 0. The request output, the vector output, the level output and the recorded vector are also 0.
- R2: A high level on an event input at a clock edge sets that source's flag on that edge. If the source is enabled and may be taken, the request output rises on the same edge. Event bit i maps to vector i: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 5 timer 2. Event bit 4 has no effect.
- R3: When enable-register bit 7 (master) is 0, no request is raised, whatever the per-source enable bits say.
- R4: Enable-register bit i (0..5) enables vector i. Bit 6 has no effect. A flag whose enable bit is 0 never wins and never blocks a lower-ordered source.
- R5: Among candidates of the same level, the lowest vector number wins. The order is 0, 1, 2, 3, 4, 5.
- R6: Priority-register bit i (0..5) set to 1 puts vector i in the upper level. An upper-level candidate beats every lower-level candidate, whatever the fixed order. The level output is 1 for an upper-level winner.
- R7: Vector 4 (serial) requests while its receive flag or its transmit flag is set. An acknowledge does not clear them. A write to address 2 clears the receive flag when data bit 0 is 1, and clears the transmit flag when data bit 1 is 1.
- R8: An acknowledge while the request output is 1 records the vector on the recorded-vector output. It clears that source's flag (except for vector 4) and sets in-service bit 1 (upper) or bit 0 (lower) according to the level output. An acknowledge while the request output is 0 has no effect.
- R9: While in-service bit 0 is set and bit 1 is clear, only an upper-level candidate raises the request. While in-service bit 1 is set, no request is raised.
- R10: A return strobe clears in-service bit 1 if it is set, and otherwise clears bit 0. The request is re-evaluated on the same edge.
- R11: When a flag is set and cleared on the same edge (by acknowledge or by a serial clear write), the flag stays set.
- R12: A write to address 0 loads the enable register and a write to address 1 loads the priority register, both on the write edge. The request output reflects the new value one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Device event per vector; bit 4 unused |
| rx_evt_i | input | 1 | Serial receive-complete event |
| tx_evt_i | input | 1 | Serial transmit-complete event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 enable, 1 priority, 2 serial flag clear |
| wr_data_i | input | 8 | Write data |
| irq_ack_i | input | 1 | Core acknowledge of the current request |
| reti_i | input | 1 | Core return-from-service strobe |
| irq_req_o | output | 1 | Registered service request |
| irq_vec_o | output | 3 | Vector of the requesting source |
| irq_lvl_o | output | 1 | Level of the requesting source (1 = upper) |
| act_vec_o | output | 3 | Vector recorded at the last acknowledge |
| in_svc_o | output | 2 | In-service bits: bit 1 upper, bit 0 lower |

## Verification
The hardest state to reach is the nested one. A lower-level service must be active, then be interrupted by an upper-level request, and a second lower-level candidate must be left waiting behind both. The return strobes must then unwind the levels in the right order. The bench reaches this state with directed acknowledges and returns. It checks after each step that the waiting source stays blocked until both in-service bits are clear. Same-edge collisions between a set and a clear are forced by driving the acknowledge, or the serial clear write, in the same cycle as a fresh event.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int NSRC    = 6;
    parameter int REGW    = 8;
    parameter int IDXW    = $clog2(NSRC);
    parameter int SER_IDX = 4;
    parameter int MEN_BIT = 7;
    parameter int ADDRW   = 2;

    localparam logic [ADDRW-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDRW-1:0] A_PRIO   = 2'd1;
    localparam logic [ADDRW-1:0] A_SERCLR = 2'd2;

    typedef struct packed {
        logic [NSRC-1:0] flg;
        logic            rx;
        logic            tx;
    } flag_st;

    typedef struct packed {
        logic            men;
        logic [NSRC-1:0] sen;
        logic [NSRC-1:0] pri;
        logic [1:0]      svc;
        logic            req;
        logic [IDXW-1:0] vec;
        logic            lvl;
        logic [IDXW-1:0] act;
    } ctl_st;
endpackage

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            rx_set_i,
    input  logic            tx_set_i,
    input  logic            rx_clr_i,
    input  logic            tx_clr_i,
    output logic [NSRC-1:0] pend_nxt_o
);
    flag_st fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        for (int k = 0; k < NSRC; k++) begin
            fl_d.flg[k] = set_i[k] | (fl_q.flg[k] & ~clr_i[k]);
        end
        fl_d.rx = rx_set_i | (fl_q.rx & ~rx_clr_i);
        fl_d.tx = tx_set_i | (fl_q.tx & ~tx_clr_i);
        pend_nxt_o = fl_d.flg;
        pend_nxt_o[SER_IDX] = fl_d.rx | fl_d.tx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_chk
        if (k != SER_IDX) begin : g_dev
            // R2, R11: a set always lands, even against a clear
            a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[k] |=> fl_q.flg[k]);
            // R8: a lone clear removes the flag
            a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[k] && !set_i[k]) |=> !fl_q.flg[k]);
        end
    end

    // R7: serial receive flag holds until software clears it
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.rx && !rx_clr_i) |=> fl_q.rx);
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] elig_i,
    input  logic [NSRC-1:0] prio_i,
    output logic            found_o,
    output logic            hi_o,
    output logic [IDXW-1:0] idx_o
);
    logic [NSRC-1:0] hi_set, cand;

    always_comb begin
        hi_set  = elig_i & prio_i;
        hi_o    = |hi_set;
        cand    = hi_o ? hi_set : elig_i;
        found_o = |cand;
        idx_o   = '0;
        for (int k = NSRC-1; k >= 0; k--) begin
            if (cand[k]) idx_o = IDXW'(k);
        end
    end

    // R5: winner is always an eligible source
    a_r5_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> elig_i[idx_o]);
    // R6: any upper-level candidate forces an upper-level winner
    a_r6_upper_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && |(elig_i & prio_i)) |-> prio_i[idx_o]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              rx_evt_i,
    input  logic              tx_evt_i,
    input  logic              wr_en_i,
    input  logic [ADDRW-1:0]  wr_addr_i,
    input  logic [REGW-1:0]   wr_data_i,
    input  logic              irq_ack_i,
    input  logic              reti_i,
    output logic              irq_req_o,
    output logic [IDXW-1:0]   irq_vec_o,
    output logic              irq_lvl_o,
    output logic [IDXW-1:0]   act_vec_o,
    output logic [1:0]        in_svc_o
);
    localparam logic [NSRC-1:0] DEV_MASK = ~(NSRC'(1) << SER_IDX);

    ctl_st c_d, c_q;

    logic            take;
    logic [NSRC-1:0] clr_vec;
    logic            rx_clr, tx_clr;
    logic [NSRC-1:0] pend_nxt, elig;
    logic            found, hi;
    logic [IDXW-1:0] idx;

    assign take   = irq_ack_i & c_q.req;
    assign rx_clr = wr_en_i && (wr_addr_i == A_SERCLR) && wr_data_i[0];
    assign tx_clr = wr_en_i && (wr_addr_i == A_SERCLR) && wr_data_i[1];

    always_comb begin
        clr_vec = '0;
        if (take && (c_q.vec != IDXW'(SER_IDX))) clr_vec[c_q.vec] = 1'b1;
    end

    intc_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_i & DEV_MASK),
        .clr_i      (clr_vec),
        .rx_set_i   (rx_evt_i),
        .tx_set_i   (tx_evt_i),
        .rx_clr_i   (rx_clr),
        .tx_clr_i   (tx_clr),
        .pend_nxt_o (pend_nxt)
    );

    assign elig = pend_nxt & c_q.sen & {NSRC{c_q.men}};

    intc_pick i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig_i  (elig),
        .prio_i  (c_q.pri),
        .found_o (found),
        .hi_o    (hi),
        .idx_o   (idx)
    );

    always_comb begin
        c_d = c_q;
        if (wr_en_i && wr_addr_i == A_ENABLE) begin
            c_d.men = wr_data_i[MEN_BIT];
            c_d.sen = wr_data_i[NSRC-1:0];
        end
        if (wr_en_i && wr_addr_i == A_PRIO) c_d.pri = wr_data_i[NSRC-1:0];
        if (reti_i) begin
            if (c_q.svc[1]) c_d.svc[1] = 1'b0;
            else            c_d.svc[0] = 1'b0;
        end
        if (take) begin
            c_d.svc[c_q.lvl] = 1'b1;
            c_d.act          = c_q.vec;
        end
        c_d.req = found && !c_d.svc[1] && (!c_d.svc[0] || hi);
        c_d.vec = found ? idx : '0;
        c_d.lvl = found && hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq_req_o = c_q.req;
    assign irq_vec_o = c_q.vec;
    assign irq_lvl_o = c_q.lvl;
    assign act_vec_o = c_q.act;
    assign in_svc_o  = c_q.svc;

    // R3: a request needs the master enable as it stood at the decision
    a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.req |-> $past(c_q.men));
    // R9: upper service blocks everything
    a_r9_upper_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.svc[1] |-> !c_q.req);
    // R9: lower service admits only upper requests
    a_r9_lower_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.svc[0] && c_q.req) |-> c_q.lvl);
    // R8: acknowledge marks the winner's level in service
    a_r8_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> c_q.svc[$past(c_q.lvl)]);
    // R10: return ends the upper service first
    a_r10_reti_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && c_q.svc[1]) |=> !c_q.svc[1]);
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] evt_i;
    logic       rx_evt_i, tx_evt_i;
    logic       wr_en_i;
    logic [1:0] wr_addr_i;
    logic [7:0] wr_data_i;
    logic       irq_ack_i, reti_i;
    logic       irq_req_o;
    logic [2:0] irq_vec_o;
    logic       irq_lvl_o;
    logic [2:0] act_vec_o;
    logic [1:0] in_svc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rx_evt_i(rx_evt_i),
        .tx_evt_i(tx_evt_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .irq_ack_i(irq_ack_i), .reti_i(reti_i),
        .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o),
        .act_vec_o(act_vec_o), .in_svc_o(in_svc_o)
    );

    // {enable, priority, events, {tx,rx}, expected req, expected vector}
    localparam logic [27:0] TBL [NVEC] = '{
        {8'h81, 8'h00, 6'h01, 2'b00, 1'b1, 3'd0},  // R2 external 0
        {8'h01, 8'h00, 6'h01, 2'b00, 1'b0, 3'd0},  // R3 master off
        {8'hBF, 8'h00, 6'h2F, 2'b11, 1'b1, 3'd0},  // R5 all pending
        {8'hBF, 8'h00, 6'h28, 2'b00, 1'b1, 3'd3},  // R5 timer1 over timer2
        {8'hBF, 8'h20, 6'h21, 2'b00, 1'b1, 3'd5},  // R6 timer2 upper
        {8'h90, 8'h00, 6'h00, 2'b01, 1'b1, 3'd4},  // R7 receive
        {8'h90, 8'h00, 6'h00, 2'b10, 1'b1, 3'd4},  // R7 transmit
        {8'hC0, 8'h00, 6'h02, 2'b00, 1'b0, 3'd0},  // R4 bit 6 only
        {8'h84, 8'h00, 6'h05, 2'b00, 1'b1, 3'd2},  // R4 masked ext0
        {8'hBF, 8'h00, 6'h10, 2'b00, 1'b0, 3'd0},  // R2 event bit 4
        {8'hBF, 8'h14, 6'h05, 2'b10, 1'b1, 3'd2}   // R6 two upper
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_i = '0; rx_evt_i = 0; tx_evt_i = 0;
        wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0; irq_ack_i = 0; reti_i = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 0;
    endtask

    task automatic pulse(input logic [5:0] e, input logic [1:0] s);
        evt_i = e; rx_evt_i = s[0]; tx_evt_i = s[1];
        tick();
        evt_i = '0; rx_evt_i = 0; tx_evt_i = 0;
    endtask

    task automatic ack();
        irq_ack_i = 1; tick(); irq_ack_i = 0;
    endtask

    task automatic reti();
        reti_i = 1; tick(); reti_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 req", {7'd0, irq_req_o}, 8'd0);
        chk("R1 vec", {5'd0, irq_vec_o}, 8'd0);
        chk("R1 lvl", {7'd0, irq_lvl_o}, 8'd0);
        chk("R1 act", {5'd0, act_vec_o}, 8'd0);
        chk("R1 svc", {6'd0, in_svc_o}, 8'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            wr(2'd0, TBL[i][27:20]);
            wr(2'd1, TBL[i][19:12]);
            pulse(TBL[i][11:6], TBL[i][5:4]);
            chk($sformatf("vector %0d req (R2-R7 table)", i), {7'd0, irq_req_o}, {7'd0, TBL[i][3]});
            if (TBL[i][3])
                chk($sformatf("vector %0d vec", i), {5'd0, irq_vec_o}, {5'd0, TBL[i][2:0]});
        end

        // R8 R9 R10 nesting
        do_reset();
        wr(2'd0, 8'h8B); wr(2'd1, 8'h08);
        pulse(6'h01, 2'b00);
        chk("R9 low req", {7'd0, irq_req_o}, 8'd1);
        chk("R6 low level", {7'd0, irq_lvl_o}, 8'd0);
        ack();
        chk("R8 svc low", {6'd0, in_svc_o}, 8'h01);
        chk("R8 act", {5'd0, act_vec_o}, 8'd0);
        chk("R8 flag cleared", {7'd0, irq_req_o}, 8'd0);
        pulse(6'h02, 2'b00);
        chk("R9 low blocked by low", {7'd0, irq_req_o}, 8'd0);
        pulse(6'h08, 2'b00);
        chk("R9 upper preempts", {7'd0, irq_req_o}, 8'd1);
        chk("R9 upper vec", {5'd0, irq_vec_o}, 8'd3);
        chk("R6 upper level", {7'd0, irq_lvl_o}, 8'd1);
        ack();
        chk("R8 svc both", {6'd0, in_svc_o}, 8'h03);
        chk("R8 act upper", {5'd0, act_vec_o}, 8'd3);
        chk("R9 upper blocks", {7'd0, irq_req_o}, 8'd0);
        reti();
        chk("R10 upper cleared", {6'd0, in_svc_o}, 8'h01);
        chk("R9 still blocked", {7'd0, irq_req_o}, 8'd0);
        reti();
        chk("R10 low cleared", {6'd0, in_svc_o}, 8'h00);
        chk("R10 waiting req", {7'd0, irq_req_o}, 8'd1);
        chk("R10 waiting vec", {5'd0, irq_vec_o}, 8'd1);
        ack();
        chk("R8 act timer0", {5'd0, act_vec_o}, 8'd1);
        reti();
        chk("R8 nothing left", {7'd0, irq_req_o}, 8'd0);
        ack();
        chk("R8 ack without req", {6'd0, in_svc_o}, 8'h00);

        // R7 serial flags stay until software clears
        do_reset();
        wr(2'd0, 8'h90);
        pulse(6'h00, 2'b01);
        ack();
        chk("R7 svc", {6'd0, in_svc_o}, 8'h01);
        chk("R7 blocked", {7'd0, irq_req_o}, 8'd0);
        reti();
        chk("R7 flag kept", {7'd0, irq_req_o}, 8'd1);
        chk("R7 vec", {5'd0, irq_vec_o}, 8'd4);
        wr(2'd2, 8'h02);
        chk("R7 tx clear leaves rx", {7'd0, irq_req_o}, 8'd1);
        rx_evt_i = 1;
        wr(2'd2, 8'h01);
        rx_evt_i = 0;
        chk("R11 serial set wins", {7'd0, irq_req_o}, 8'd1);
        wr(2'd2, 8'h01);
        chk("R7 rx cleared", {7'd0, irq_req_o}, 8'd0);

        // R11 acknowledge against a new event
        do_reset();
        wr(2'd0, 8'h81);
        pulse(6'h01, 2'b00);
        evt_i = 6'h01;
        ack();
        evt_i = '0;
        chk("R11 svc", {6'd0, in_svc_o}, 8'h01);
        reti();
        chk("R11 flag survived", {7'd0, irq_req_o}, 8'd1);

        // R12 write latency
        do_reset();
        pulse(6'h01, 2'b00);
        chk("R4 disabled", {7'd0, irq_req_o}, 8'd0);
        wr(2'd0, 8'h81);
        chk("R12 not yet", {7'd0, irq_req_o}, 8'd0);
        tick();
        chk("R12 next edge", {7'd0, irq_req_o}, 8'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule